// File: doc/BRIEF.md
# Conditional-Sum Binary Adder

This block adds two unsigned operands of `WIDTH` bits and returns a `WIDTH+1`-bit result, the top bit being the carry out. The adder is built by recursion. At every level the operand pair is cut into a lower and an upper half. Each half is handled by a smaller copy of the same adder.

The upper half is computed twice at the same time, once with its incoming carry tied to 0 and once tied to 1. The carry leaving the lower half then picks one of the two upper candidates through a 2:1 selector. Because of this, the carry never ripples across the full width. The longest path is one full-adder cell plus one selector per level, so the delay grows with log2(WIDTH) rather than with WIDTH. The recursion ends at width one, where a single full-adder cell takes the carry in.

The result can go through one output register, chosen by `REG_OUT`, so that the adder fits a timing budget. With `REG_OUT` cleared the block is purely combinational and ignores its clock and reset. The block has no state machine. Its only stored state is the optional output register, which has two conditions: cleared (while reset is low) and loaded (on every rising clock edge after reset).

Top module: `csa_adder`

## Requirements
- R1: `sum` equals the arithmetic sum of `a` and `b` as an unsigned `WIDTH+1`-bit value, with bit `WIDTH` being the carry out, for every operand pair.
- R2: With `REG_OUT`=1, `sum` shows the result for the operands present at the most recent rising edge of `clk`, so the latency is exactly one clock.
- R3: With `REG_OUT`=1, a low level on `rst_n` clears `sum` to zero at once, without waiting for a clock edge, and keeps it zero while `rst_n` stays low.
- R4: Adding zero to an operand returns that operand in bits `WIDTH-1:0`, with bit `WIDTH` equal to 0.
- R5: An all-ones operand plus one gives bit `WIDTH`=1 and zero in every lower bit, so the carry has propagated through every split level.
- R6: A carry out of bit `WIDTH/2-1` of the lower half reaches the upper half: 0x0000FFFF + 1 at width 32 gives 0x000010000.
- R7: With `REG_OUT`=0, `sum` follows `a` and `b` with no clock edge, and this holds for every operand pair at width 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous clear of the output register |
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH+1 | Sum; bit WIDTH is the carry out |

## Verification
Two functions can land on the same clock edge: the output register clearing and the register capturing a new result. The bench provokes this by holding operands that give a large nonzero sum (an all-ones sum with its carry set) while `rst_n` is low across a rising edge. It judges the case by requiring `sum` to read zero both immediately and after that edge, and the correct sum one clock after release.

A second pairing is resolved inside a single evaluation. With all-ones plus one, the carry-out selection of the lower half and the carry out of the root level depend on the same propagate chain. The bench judges this from the full result word.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // True when w is a positive power of two.
    function automatic bit is_pow2(input int w);
        return (w > 0) && ((w & (w - 1)) == 0);
    endfunction

    // Number of split levels above the single-bit leaves.
    function automatic int split_levels(input int w);
        int lv;
        int r;
        lv = 0;
        r  = w;
        while (r > 1) begin
            r  = (r + 1) / 2;
            lv = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/csa_fa.sv
module csa_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = x ^ y ^ ci;
    assign co = (x & y) | (y & ci) | (ci & x);
endmodule

// File: rtl/csa_sel.sv
module csa_sel #(
    parameter int W = 2
) (
    input  logic         pick,
    input  logic [W-1:0] d0,
    input  logic [W-1:0] d1,
    output logic [W-1:0] y
);
    assign y = pick ? d1 : d0;
endmodule

// File: rtl/csa_node.sv
module csa_node #(
    parameter int W = 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W:0]   s
);
    generate
        if (W == 1) begin : g_leaf
            csa_fa u_fa (
                .x (a[0]),
                .y (b[0]),
                .ci(cin),
                .s (s[0]),
                .co(s[1])
            );
        end else begin : g_split
            localparam int LO_W = W / 2;
            localparam int HI_W = W - LO_W;

            logic [LO_W:0] lo_res;
            logic [HI_W:0] hi_c0;
            logic [HI_W:0] hi_c1;

            csa_node #(.W(LO_W)) u_lo (
                .a  (a[LO_W-1:0]),
                .b  (b[LO_W-1:0]),
                .cin(cin),
                .s  (lo_res)
            );

            csa_node #(.W(HI_W)) u_hi_c0 (
                .a  (a[W-1:LO_W]),
                .b  (b[W-1:LO_W]),
                .cin(1'b0),
                .s  (hi_c0)
            );

            csa_node #(.W(HI_W)) u_hi_c1 (
                .a  (a[W-1:LO_W]),
                .b  (b[W-1:LO_W]),
                .cin(1'b1),
                .s  (hi_c1)
            );

            csa_sel #(.W(HI_W + 1)) u_pick (
                .pick(lo_res[LO_W]),
                .d0  (hi_c0),
                .d1  (hi_c1),
                .y   (s[W:LO_W])
            );

            assign s[LO_W-1:0] = lo_res[LO_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH:0]   sum
);
    localparam int LEVELS = csa_pkg::split_levels(WIDTH);

    logic [WIDTH:0] raw_sum;

    generate
        if (!csa_pkg::is_pow2(WIDTH) || LEVELS < 0) begin : g_bad_width
            $error("csa_adder: WIDTH must be a power of two");
        end
    endgenerate

    csa_node #(.W(WIDTH)) u_root (
        .a  (a),
        .b  (b),
        .cin(1'b0),
        .s  (raw_sum)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sum <= '0;
                end else begin
                    sum <= raw_sum;
                end
            end
        end else begin : g_comb
            assign sum = raw_sum;
        end
    endgenerate
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH:0]   sum
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    generate
        if (REG_OUT) begin : g_reg_chk
            // R1 and R2: one-cycle delayed arithmetic sum
            a_r2_one_cycle_sum: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok |-> sum == ({1'b0, $past(a)} + {1'b0, $past(b)}));
            // R3: held in reset gives zero
            a_r3_reset_clear: assert property (@(posedge clk)
                !rst_n |=> sum == '0);
            // R4: zero operand passes through
            a_r4_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(b) == '0) |-> sum == {1'b0, $past(a)});
            // R5: all ones plus one carries out
            a_r5_full_carry: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(a) == {WIDTH{1'b1}} && $past(b) == WIDTH'(1))
                |-> (sum[WIDTH] && sum[WIDTH-1:0] == '0));
        end else begin : g_comb_chk
            // R7 and R1: same-cycle arithmetic sum
            a_r7_comb_sum: assert property (@(posedge clk)
                sum == ({1'b0, a} + {1'b0, b}));
            // R4: zero operand passes through
            a_r4_zero_identity_c: assert property (@(posedge clk)
                (b == '0) |-> sum == {1'b0, a});
            // R5: all ones plus one carries out
            a_r5_full_carry_c: assert property (@(posedge clk)
                (a == {WIDTH{1'b1}} && b == WIDTH'(1)) |-> (sum[WIDTH] && sum[WIDTH-1:0] == '0));
            // R1: carry bit set only when sum exceeds range
            a_r1_carry_bound: assert property (@(posedge clk)
                sum[WIDTH] |-> (a != '0 && b != '0));
        end
    endgenerate
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .a    (a),
    .b    (b),
    .sum  (sum)
);

// File: tb/csa_adder_tb.sv
module csa_adder_tb;
    localparam int W  = 32;
    localparam int WS = 4;
    localparam int NV = 10;

    logic          clk;
    logic          rst_n;
    logic [W-1:0]  a;
    logic [W-1:0]  b;
    logic [W:0]    sum;
    logic [WS-1:0] sa;
    logic [WS-1:0] sb;
    logic [WS:0]   ssum;

    int n_run;
    int n_fail;

    // {a, b, expected sum}
    localparam logic [3*W:0] VEC [NV] = '{
        {32'h00000000, 32'h00000000, 33'h000000000},
        {32'h00000001, 32'h00000001, 33'h000000002},
        {32'hFFFFFFFF, 32'h00000001, 33'h100000000},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 33'h1FFFFFFFE},
        {32'h0000FFFF, 32'h00000001, 33'h000010000},
        {32'h12345678, 32'h00000000, 33'h012345678},
        {32'h80000000, 32'h80000000, 33'h100000000},
        {32'hAAAAAAAA, 32'h55555555, 33'h0FFFFFFFF},
        {32'h7FFFFFFF, 32'h00000001, 33'h080000000},
        {32'hDEADBEEF, 32'h01234567, 33'h0DFD10456}
    };

    csa_adder #(.WIDTH(W), .REG_OUT(1'b1)) u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (a),
        .b    (b),
        .sum  (sum)
    );

    csa_adder #(.WIDTH(WS), .REG_OUT(1'b0)) u_dut_small (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (sa),
        .b    (sb),
        .sum  (ssum)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check33(input string req, input logic [W:0] got, input logic [W:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sum=%h expected %h", req, got, exp);
        end
    endtask

    // drive at negedge, result visible at the following negedge
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        a = x;
        b = y;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1500000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        n_run  = 0;
        n_fail = 0;
        rst_n  = 1'b0;
        a      = '1;
        b      = '1;
        sa     = '0;
        sb     = '0;
        #1;
        // R3: reset state with nonzero operands pending
        check33("R3 reset state", sum, '0);
        @(posedge clk);
        @(negedge clk);
        // R3: reset and capture on the same edge
        check33("R3 clear across edge", sum, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check33("R2 first capture after release", sum, 33'h1FFFFFFFE);

        // table walk: R1, R2, R4, R5, R6
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][3*W:2*W+1], VEC[i][2*W:W+1]);
            check33($sformatf("R1 R2 R4 R5 R6 vector %0d", i), sum, VEC[i][W:0]);
        end

        // R5 directed: all ones plus one
        apply('1, 32'h1);
        check33("R5 full carry", sum, {1'b1, {W{1'b0}}});
        // R6 directed: mid split carry
        apply(32'h0000FFFF, 32'h1);
        check33("R6 mid carry", sum, 33'h000010000);
        // R4 directed: zero on the a side
        apply(32'h0, 32'hCAFE0123);
        check33("R4 zero a", sum, 33'h0CAFE0123);

        // R2: latency exactly one clock
        @(negedge clk);
        a = 32'h00000010;
        b = 32'h00000020;
        #1;
        check33("R2 no change before edge", sum, 33'h0CAFE0123);
        @(negedge clk);
        check33("R2 one clock latency", sum, 33'h000000030);

        // R1: pseudo-random operands
        ra = 32'h1234ABCD;
        rb = 32'h9E3779B9;
        for (int k = 0; k < 200; k++) begin
            ra = ra ^ (ra << 13);
            ra = ra ^ (ra >> 17);
            ra = ra ^ (ra << 5);
            rb = rb + 32'h9E3779B9 + ra;
            apply(ra, rb);
            check33("R1 random", sum, {1'b0, ra} + {1'b0, rb});
        end

        // R3: asynchronous clear mid-run
        @(negedge clk);
        a = '1;
        b = '1;
        @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        check33("R3 async clear", sum, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check33("R3 recovery", sum, 33'h1FFFFFFFE);

        // R7: exhaustive combinational width 4
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                sa = WS'(x);
                sb = WS'(y);
                #1;
                n_run++;
                if (ssum !== 5'(x + y)) begin
                    n_fail++;
                    $display("FAIL R7: %0d+%0d sum=%0d expected %0d", x, y, ssum, x + y);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule